// File: doc/BRIEF.md
# Seven-Level Multicarrier PWM Gate Generator

This block turns a stream of signed reference samples into the ten gate signals of one single-phase seven-level inverter leg. The leg is a reduced-switch multilevel DC-link stage that feeds an H-bridge. Inside the block, one up/down counter produces a triangular carrier. Six copies of that carrier are shifted into six adjacent bands of the reference range. The held reference is compared with all six every cycle. The number of carriers it lies above, less three, is the output level, a value from -3 to +3 units of DC voltage. A fixed decode then turns that level into the ten-bit gate word.

The reference enters over a valid/ready handshake. The block raises `ref_ready` for exactly one cycle per carrier period, at the carrier peak. A sample moves only in a cycle where `ref_valid` and `ref_ready` are both high. When the source has no valid sample at a peak, the previous sample stays in force for another whole period. A source that wants a new sample used must hold `ref_valid` and `ref_data` until the transfer. The output frequency and the modulation depth therefore follow the frequency and amplitude of the sample stream the source supplies. The carrier half-period comes from the plain `period` input, which is read only at carrier valleys.

Top module: `mlpwm_gate_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, until the first comparison is registered, `gate` equals 10'b1010101010 (the level-0 word) and `level_idx` is 0.
- R2: With an effective half-period P, the carrier count c rises 0,1,…,P and then falls P-1,…,1, so one period is 2P cycles. `ref_ready` is high exactly in the cycle where c equals P while rising.
- R3: The `period` input is read in every cycle where c is 0 and takes effect from that cycle on. A value of 0 is treated as 1, which gives a two-cycle period.
- R4: The held reference is loaded from `ref_data` only in a cycle with `ref_valid` and `ref_ready` both high. In every other cycle it keeps its value. The held value is 0 after reset.
- R5: Carrier k, for k = 0..5, is (k-3)·P + c. The level equals the number of carriers that are strictly below the held reference, minus 3.
- R6: Gate words have bit 9 as the first switch and bit 0 as the tenth. Level 0 gives 1010101010, +1 gives 1001001100, +2 gives 1001001110 and +3 gives 1001100110.
- R7: Level -1 gives 0110110011, level -2 gives 0110011011 and level -3 gives 0110011001.
- R8: `gate` and `level_idx` are registered. They show the comparison made with the counter, period and held reference of the previous cycle.
- R9: In every cycle, bits 9 and 8 of `gate` differ, and bits 7 and 6 of `gate` differ.
- R10: A held reference above 3P gives level +3 in every cycle. A held reference at or below -3P gives level -3 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_valid | input | 1 | Reference sample offered |
| ref_ready | output | 1 | High at the carrier peak; the sample is taken when this and ref_valid are both high |
| ref_data | input | REF_W (16) | Signed reference sample |
| period | input | PER_W (10) | Carrier half-period in cycles, 0 read as 1 |
| gate | output | 10 | Gate word; bit 9 is the first switch |
| level_idx | output | 3 | Signed present output level, -3..+3 |

## Verification
The assertions check properties on every cycle. They check that the counter stays within the period in force and reverses at the peak and at the valley. They check that the held reference moves only on a handshake, that each bridge pair stays complementary, and that the level never takes the unused code -4. Only the bench scenarios can show the exact staircase. These scenarios cover period changes made at the valleys, a zero period, peaks with no valid sample, and references driven far past both ends of the range. In each of them, the bench compares the level and the gate word on every cycle against a behavioural model.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;
  localparam int LEVELS = 7;
  localparam int NCAR   = LEVELS - 1;
  localparam int HALF   = NCAR / 2;
  localparam int GATE_W = 10;
  localparam int LVL_W  = 3;

  typedef logic [GATE_W-1:0]        gate_t;
  typedef logic signed [LVL_W-1:0]  lvl_t;

  localparam gate_t GATE_ZERO = 10'b1010101010;

  // bit 9 drives the first switch of the leg
  function automatic gate_t level_to_gate(input lvl_t l);
    gate_t g;
    case (l)
      3'sd1:   g = 10'b1001001100;
      3'sd2:   g = 10'b1001001110;
      3'sd3:   g = 10'b1001100110;
      -3'sd1:  g = 10'b0110110011;
      -3'sd2:  g = 10'b0110011011;
      -3'sd3:  g = 10'b0110011001;
      default: g = GATE_ZERO;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/mlpwm_carrier.sv
module mlpwm_carrier #(
  parameter int PER_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period,
  output logic [PER_W-1:0] cnt,
  output logic [PER_W-1:0] per_use,
  output logic             at_peak
);
  logic             up_q;
  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] per_q;

  // the half-period is re-read only at a valley
  always_comb begin
    if (cnt_q == '0) per_use = (period == '0) ? PER_W'(1) : period;
    else             per_use = per_q;
    at_peak = up_q && (cnt_q >= per_use);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q  <= 1'b1;
      cnt_q <= '0;
      per_q <= PER_W'(1);
    end else begin
      per_q <= per_use;
      if (up_q) begin
        if (at_peak) begin
          up_q  <= 1'b0;
          cnt_q <= per_use - PER_W'(1);
        end else begin
          cnt_q <= cnt_q + PER_W'(1);
        end
      end else if (cnt_q == '0) begin
        up_q  <= 1'b1;
        cnt_q <= PER_W'(1);
      end else begin
        cnt_q <= cnt_q - PER_W'(1);
      end
    end
  end

  assign cnt = cnt_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= per_q); // R2
  AST_PEAK_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    at_peak |=> !up_q); // R2
  AST_VALLEY_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_q && cnt_q == '0) |=> (up_q && cnt_q == PER_W'(1))); // R3
endmodule

// File: rtl/mlpwm_ref_hold.sv
module mlpwm_ref_hold #(
  parameter int REF_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    window,
  input  logic                    ref_valid,
  input  logic signed [REF_W-1:0] ref_data,
  output logic                    ref_ready,
  output logic signed [REF_W-1:0] ref_q
);
  assign ref_ready = window;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ref_q <= '0;
    else if (ref_valid && ref_ready) ref_q <= ref_data;
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_valid && ref_ready) |=> $stable(ref_q)); // R4
endmodule

// File: rtl/mlpwm_level_cmp.sv
module mlpwm_level_cmp
  import mlpwm_pkg::*;
#(
  parameter int REF_W = 16,
  parameter int PER_W = 10
) (
  input  logic signed [REF_W-1:0] ref_q,
  input  logic [PER_W-1:0]        cnt,
  input  logic [PER_W-1:0]        per_use,
  output lvl_t                    level
);
  localparam int CW = ((REF_W > PER_W + 3) ? REF_W : PER_W + 3) + 1;

  logic signed [CW-1:0] ref_s, per_s, cnt_s;
  logic [NCAR-1:0]      above;

  assign ref_s = CW'(ref_q);
  assign per_s = $signed(CW'(per_use));
  assign cnt_s = $signed(CW'(cnt));

  for (genvar k = 0; k < NCAR; k++) begin : g_band
    localparam logic signed [CW-1:0] OFF = CW'(k - HALF);
    logic signed [CW-1:0] carrier;
    assign carrier  = OFF * per_s + cnt_s;
    assign above[k] = ref_s > carrier;
  end

  assign level = lvl_t'($countones(above)) - lvl_t'(HALF);
endmodule

// File: rtl/mlpwm_gate_reg.sv
module mlpwm_gate_reg
  import mlpwm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  lvl_t  level,
  output gate_t gate_q,
  output lvl_t  level_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q  <= GATE_ZERO;
      level_q <= '0;
    end else begin
      gate_q  <= level_to_gate(level);
      level_q <= level;
    end
  end

  AST_LEG_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q[9] != gate_q[8]) && (gate_q[7] != gate_q[6])); // R9
  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    level_q != -3'sd4); // R5
endmodule

// File: rtl/mlpwm_gate_top.sv
module mlpwm_gate_top
  import mlpwm_pkg::*;
#(
  parameter int REF_W = 16,
  parameter int PER_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_valid,
  output logic                    ref_ready,
  input  logic signed [REF_W-1:0] ref_data,
  input  logic [PER_W-1:0]        period,
  output logic [GATE_W-1:0]       gate,
  output logic signed [LVL_W-1:0] level_idx
);
  logic [PER_W-1:0]        cnt, per_use;
  logic                    at_peak;
  logic signed [REF_W-1:0] ref_q;
  lvl_t                    level_c, level_q;
  gate_t                   gate_q;

  mlpwm_carrier #(.PER_W(PER_W)) u_car (
    .clk(clk), .rst_n(rst_n), .period(period),
    .cnt(cnt), .per_use(per_use), .at_peak(at_peak)
  );

  mlpwm_ref_hold #(.REF_W(REF_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .window(at_peak),
    .ref_valid(ref_valid), .ref_data(ref_data),
    .ref_ready(ref_ready), .ref_q(ref_q)
  );

  mlpwm_level_cmp #(.REF_W(REF_W), .PER_W(PER_W)) u_cmp (
    .ref_q(ref_q), .cnt(cnt), .per_use(per_use), .level(level_c)
  );

  mlpwm_gate_reg u_gate (
    .clk(clk), .rst_n(rst_n), .level(level_c),
    .gate_q(gate_q), .level_q(level_q)
  );

  assign gate      = gate_q;
  assign level_idx = level_q;

  AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ready |=> !ref_ready); // R2
endmodule

// File: tb/sim_mlpwm_gate_top.sv
module sim_mlpwm_gate_top;
  localparam int REF_W = 16;
  localparam int PER_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_valid = 1'b0;
  logic ref_ready;
  logic signed [REF_W-1:0] ref_data = '0;
  logic [PER_W-1:0] period = 10'd4;
  logic [9:0] gate;
  logic signed [2:0] level_idx;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mlpwm_gate_top #(.REF_W(REF_W), .PER_W(PER_W)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_ready(ref_ready),
    .ref_data(ref_data), .period(period), .gate(gate), .level_idx(level_idx)
  );

  // behavioural model state
  int m_cnt, m_per, m_ref, m_lvl;
  bit m_up;

  function automatic logic [9:0] exp_gate(input int l);
    case (l)
      1:  return 10'b1001001100;
      2:  return 10'b1001001110;
      3:  return 10'b1001100110;
      -1: return 10'b0110110011;
      -2: return 10'b0110011011;
      -3: return 10'b0110011001;
      default: return 10'b1010101010;
    endcase
  endfunction

  function automatic int eff_per(input int c, input int pin, input int pq);
    if (c != 0) return pq;
    return (pin == 0) ? 1 : pin;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_up = 1'b1; m_per = 1; m_ref = 0; m_lvl = 0;
    end else begin
      int p, n;
      bit rdy;
      p = eff_per(m_cnt, int'(period), m_per);
      rdy = m_up && (m_cnt >= p);
      n = 0;
      for (int k = 0; k < 6; k++)
        if (m_ref > (k - 3) * p + m_cnt) n++;
      m_lvl = n - 3;
      if (rdy && ref_valid) m_ref = int'(ref_data);
      m_per = p;
      if (m_up) begin
        if (rdy) begin m_up = 1'b0; m_cnt = p - 1; end
        else m_cnt = m_cnt + 1;
      end else if (m_cnt == 0) begin
        m_up = 1'b1; m_cnt = 1;
      end else m_cnt = m_cnt - 1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      cycles++;
      if (!rst_n) begin
        chk(gate == 10'b1010101010, "R1 reset gate", int'(gate), 682);
        chk(level_idx == 3'sd0, "R1 reset level", int'(level_idx), 0);
      end else begin
        int p;
        bit rdy;
        string t;
        p = eff_per(m_cnt, int'(period), m_per);
        rdy = m_up && (m_cnt >= p);
        chk(ref_ready == rdy, "R2 R3 ready", int'(ref_ready), int'(rdy));
        t = (m_ref > 3 * m_per || m_ref <= -3 * m_per) ? "R4 R5 R8 R10 level" : "R4 R5 R8 level";
        chk(int'(level_idx) == m_lvl, t, int'(level_idx), m_lvl);
        chk(gate == exp_gate(m_lvl), (m_lvl < 0) ? "R7 gate" : "R6 gate",
            int'(gate), int'(exp_gate(m_lvl)));
        chk(gate[9] != gate[8] && gate[7] != gate[6], "R9 bridge pairs", int'(gate), 0);
      end
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic drive(input bit v, input int d, input int p);
    @(negedge clk); #1;
    ref_valid = v;
    ref_data  = REF_W'(d);
    period    = PER_W'(p);
  endtask

  initial begin
    repeat (3) drive(1'b1, 9, 4);
    @(negedge clk); #1 rst_n = 1'b1;
    // sweep through all bands at P=4
    for (int i = 0; i < 300; i++) drive(1'b1, ((i * 7) % 31) - 15, 4);
    // zero period reads as one
    for (int i = 0; i < 60; i++) drive(1'b1, (i % 9) - 4, 0);
    // no valid at peaks: held sample stays
    for (int i = 0; i < 80; i++) drive(1'b0, 999, 5);
    // saturation both ways
    for (int i = 0; i < 160; i++) drive(1'b1, ((i / 20) % 2 == 0) ? 30000 : -30000, 3);
    // period changes with sparse valid
    for (int i = 0; i < 400; i++)
      drive(i % 3 != 0, ((i * 13) % 41) - 20, (i < 200) ? 9 : 2);
    // wide period slow ramp
    for (int i = 0; i < 4000; i++) drive(1'b1, (i % 1600) - 800, 300);
    drive(1'b1, 0, 4);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule